// File: doc/BRIEF.md
# Passive-Matrix Row Scan Timing Generator

This block derives all row-scan timing for a passive-matrix STN panel from one line strobe. Each time the strobe is high on a clock edge, the block moves to the next row and presents that row's number as the row address for the display memory. After the last row it returns to row 0. While row 0 is being scanned it raises a frame marker.

The block also drives the drive-polarity alternation output. In the default mode, this output inverts once per frame. In the grouped mode, it inverts after every group of `v+1` lines, where `v` is the value in the group-size input. The group count restarts at the start of every frame.

The mode bit and the group size are captured only when a frame begins. A latch strobe tells the segment data latch that a new row address is valid. Scanning never waits on, or reacts to, any host access.

Top module: `lcd_scan_timing`

## Requirements
- R1: Row address, frame marker and alternation output change only on a clock edge where `line_pulse` is high; on all other edges they hold their values.
- R2: Each clock edge with `line_pulse` high advances `row_addr` by exactly one, except from the last row.
- R3: `row_addr` stays within 0 to ROWS-1 (67 by default); a strobe taken at row ROWS-1 returns it to 0.
- R4: `frame_sync` is 1 exactly while `row_addr` is 0, and 0 otherwise.
- R5: With the captured mode bit 0, `ac_flip` inverts on the strobe that moves the row address to 0, and on no other strobe.
- R6: With the captured mode bit 1 and captured group size `v`, `ac_flip` inverts on each strobe that moves the row address to a nonzero multiple of `v+1`. On the strobe that moves it to 0, it inverts only if ROWS is a multiple of `v+1`. With `v+1` greater than ROWS, it never inverts.
- R7: `nline_en` and `nline_val` are captured only on the strobe that moves the row address to 0. Changes at any other time have no effect until the next frame starts.
- R8: `latch_stb` is high for exactly one clock, in the cycle that follows each strobe edge, which is the same cycle in which the new row address first appears. It is low at all other times.
- R9: While reset is applied, the outputs are `row_addr`=0, `frame_sync`=1, `ac_flip`=0 and `latch_stb`=0. The captured mode bit and group size are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| line_pulse | input | 1 | Line strobe; one row step per clock edge on which it is high |
| nline_val | input | NW (8) | Group size minus one for grouped alternation |
| nline_en | input | 1 | Selects grouped alternation (1) or per-frame alternation (0) |
| row_addr | output | ROW_W (7) | Row address for the display memory |
| frame_sync | output | 1 | Frame marker, high during row 0 |
| ac_flip | output | 1 | Drive polarity alternation signal |
| latch_stb | output | 1 | One-clock strobe marking a freshly updated row address |

## Verification
A wrong row count appears at the row address on the first strobe after the fault, because every strobe is compared against an independent model. A fault in the wrap decode shows at the next frame boundary as a missing or misplaced frame marker. An error in the group counter or in the captured mode shows as `ac_flip` inverting on the wrong row, within one group of lines in grouped mode or within one frame in per-frame mode. Because the group count restarts at each frame start, any such error repeats in the same rows in every frame. Changing the mode or group size in the middle of a frame tests whether capture happens too early, since the alternation output then diverges before the next row 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // Default panel geometry and register width
  localparam int unsigned DEF_ROWS = 68;
  localparam int unsigned DEF_NW   = 8;

  typedef enum logic {
    AC_PER_FRAME  = 1'b0,
    AC_PER_GROUP  = 1'b1
  } ac_mode_e;
endpackage

// File: rtl/lcd_row_counter.sv
module lcd_row_counter #(
  parameter int unsigned ROWS  = lcd_scan_pkg::DEF_ROWS,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row,
  output logic             last_row,
  output logic             frame_sync
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic             sync_q, sync_d;

  assign last_row = (row_q == ROW_MAX);

  always_comb begin
    row_d  = last_row ? '0 : row_q + 1'b1;
    sync_d = last_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      sync_q <= 1'b1;
    end else if (step) begin
      row_q  <= row_d;
      sync_q <= sync_d;
    end
  end

  assign row        = row_q;
  assign frame_sync = sync_q;
endmodule

// File: rtl/lcd_ac_gen.sv
module lcd_ac_gen #(
  parameter int unsigned NW = lcd_scan_pkg::DEF_NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wrap,
  input  logic [NW-1:0] n_in,
  input  logic          en_in,
  output logic          ac
);
  import lcd_scan_pkg::*;

  ac_mode_e      mode_q, mode_d;
  logic [NW-1:0] size_q, size_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          ac_q, ac_d;
  logic          hit, flip;

  always_comb begin
    hit    = (cnt_q == size_q);
    if (wrap)
      flip = (mode_q == AC_PER_GROUP) ? hit : 1'b1;
    else
      flip = (mode_q == AC_PER_GROUP) && hit;
    cnt_d  = (wrap || ((mode_q == AC_PER_GROUP) && hit)) ? '0 : cnt_q + 1'b1;
    ac_d   = ac_q ^ flip;
    mode_d = wrap ? ac_mode_e'(en_in) : mode_q;
    size_d = wrap ? n_in : size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AC_PER_FRAME;
      size_q <= '0;
      cnt_q  <= '0;
      ac_q   <= 1'b0;
    end else if (step) begin
      mode_q <= mode_d;
      size_q <= size_d;
      cnt_q  <= cnt_d;
      ac_q   <= ac_d;
    end
  end

  assign ac = ac_q;
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int unsigned ROWS  = lcd_scan_pkg::DEF_ROWS,
  parameter int unsigned NW    = lcd_scan_pkg::DEF_NW,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_pulse,
  input  logic [NW-1:0]    nline_val,
  input  logic             nline_en,
  output logic [ROW_W-1:0] row_addr,
  output logic             frame_sync,
  output logic             ac_flip,
  output logic             latch_stb
);
  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic last_row;
  logic wrap;

  lcd_row_counter #(.ROWS(ROWS)) u_rows (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step       (line_pulse),
    .row        (row_addr),
    .last_row   (last_row),
    .frame_sync (frame_sync)
  );

  assign wrap = line_pulse && last_row;

  lcd_ac_gen #(.NW(NW)) u_ac (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (line_pulse),
    .wrap  (wrap),
    .n_in  (nline_val),
    .en_in (nline_en),
    .ac    (ac_flip)
  );

  // Latch strobe follows the strobe edge by one clock
  logic latch_q, latch_d;
  always_comb latch_d = line_pulse;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) latch_q <= 1'b0;
    else             latch_q <= latch_d;
  end
  assign latch_stb = latch_q;
endmodule

// File: rtl/lcd_scan_timing_chk.sv
module lcd_scan_timing_chk #(
  parameter int unsigned ROWS  = lcd_scan_pkg::DEF_ROWS,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_pulse,
  input logic [ROW_W-1:0] row_addr,
  input logic             frame_sync,
  input logic             ac_flip,
  input logic             latch_stb
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_pulse |=> $stable(row_addr)); // R1
  AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_pulse |=> $stable(ac_flip)); // R1
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse && row_addr != ROW_MAX) |=> row_addr == ROW_W'($past(row_addr) + 1'b1)); // R2
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse && row_addr == ROW_MAX) |=> row_addr == '0); // R3
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row_addr <= ROW_MAX); // R3
  AST_SYNC_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync == (row_addr == '0)); // R4
  AST_LATCH_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |=> latch_stb); // R8
  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !line_pulse |=> !latch_stb); // R8
endmodule

bind lcd_scan_timing lcd_scan_timing_chk #(.ROWS(ROWS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .line_pulse (line_pulse),
  .row_addr   (row_addr),
  .frame_sync (frame_sync),
  .ac_flip    (ac_flip),
  .latch_stb  (latch_stb)
);

// File: tb/lcd_scan_timing_tb.sv
module lcd_scan_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 68;
  localparam int NW = 8;
  localparam int ROW_W = $clog2(ROWS);

  typedef struct packed {
    logic          en;
    logic [NW-1:0] n;
    logic [15:0]   pulses;
  } vec_t;

  // mode, group size minus one, strobes to apply (counts cross frames mid-way)
  localparam vec_t VECS [8] = '{
    '{1'b0, 8'd0,   16'd140},
    '{1'b1, 8'd3,   16'd150},
    '{1'b1, 8'd4,   16'd143},
    '{1'b1, 8'd0,   16'd90},
    '{1'b1, 8'd66,  16'd150},
    '{1'b1, 8'd67,  16'd150},
    '{1'b1, 8'd200, 16'd145},
    '{1'b0, 8'd5,   16'd150}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_pulse = 1'b0;
  logic [NW-1:0]    nline_val = '0;
  logic             nline_en = 1'b0;
  logic [ROW_W-1:0] row_addr;
  logic             frame_sync;
  logic             ac_flip;
  logic             latch_stb;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int   m_row = 0;
  logic m_ac = 1'b0;
  logic m_en = 1'b0;
  int   m_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timing dut_i (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
    .nline_val(nline_val), .nline_en(nline_en),
    .row_addr(row_addr), .frame_sync(frame_sync),
    .ac_flip(ac_flip), .latch_stb(latch_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_row = 0; m_ac = 1'b0; m_en = 1'b0; m_n = 0;
  endtask

  task automatic check_reset_state();
    chk("R9 row_addr", int'(row_addr), 0);
    chk("R9 frame_sync", int'(frame_sync), 1);
    chk("R9 ac_flip", int'(ac_flip), 0);
    chk("R9 latch_stb", int'(latch_stb), 0);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    #1 check_reset_state();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
  endtask

  // One strobe, checks in the following cycle, then one idle cycle
  task automatic do_pulse(input string ac_tag);
    int  nr;
    logic tog;
    @(negedge clk) line_pulse = 1'b1;
    nr = (m_row == ROWS-1) ? 0 : m_row + 1;
    if (m_en)
      tog = (nr % (m_n+1) == 0) && (nr != 0 || ROWS % (m_n+1) == 0);
    else
      tog = (nr == 0);
    m_ac = m_ac ^ tog;
    m_row = nr;
    if (nr == 0) begin
      m_en = nline_en;
      m_n  = int'(nline_val);
    end
    @(negedge clk) line_pulse = 1'b0;
    chk(nr == 0 ? "R3 row wrap" : "R2 row step", int'(row_addr), m_row);
    chk("R4 frame_sync", int'(frame_sync), (m_row == 0) ? 1 : 0);
    chk(ac_tag, int'(ac_flip), int'(m_ac));
    chk("R8 latch high", int'(latch_stb), 1);
    @(negedge clk);
    chk("R8 latch low", int'(latch_stb), 0);
    chk("R1 row hold", int'(row_addr), m_row);
    chk("R1 ac hold", int'(ac_flip), int'(m_ac));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // Vector walk: inputs change at arbitrary rows, so capture timing matters
    foreach (VECS[i]) begin
      @(negedge clk);
      nline_en  = VECS[i].en;
      nline_val = VECS[i].n;
      for (int p = 0; p < int'(VECS[i].pulses); p++)
        do_pulse(m_en ? "R6 ac grouped" : "R5 ac per frame");
    end

    // Directed R7: grouped frame in progress, change settings mid-frame
    do_reset();
    nline_en = 1'b1; nline_val = 8'd2;
    while (!(m_row == ROWS-1)) do_pulse("R5 ac per frame");
    do_pulse("R5 ac per frame");          // capture: groups of 3 from here
    for (int p = 0; p < 10; p++) do_pulse("R6 ac grouped");
    nline_en = 1'b0; nline_val = 8'd0;    // must not act until next frame
    for (int p = 0; p < 20; p++) do_pulse("R7 mid-frame change ignored");
    chk("R7 row before boundary", int'(row_addr), 30);
    while (!(m_row == ROWS-1)) do_pulse("R7 mid-frame change ignored");
    do_pulse("R7 capture at boundary");
    for (int p = 0; p < 5; p++) do_pulse("R5 ac per frame");

    // Directed R1: long idle gap
    repeat (7) @(negedge clk);
    chk("R1 row idle", int'(row_addr), m_row);
    chk("R1 sync idle", int'(frame_sync), (m_row == 0) ? 1 : 0);

    // Directed R9: reset in mid-frame
    do_pulse("R5 ac per frame");
    do_reset();
    do_pulse("R2 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule